// File: doc/BRIEF.md
# NAND Flash Device Command and Address Front-End

This block is the device-side control logic behind an 8-bit asynchronous NAND flash port. It runs on a local clock. It watches the write and read strobes for edges, and it accepts a strobe only while the chip is selected and not busy. On a write-strobe rise, the byte on the shared bus goes to the command register if command-latch is high. If address-latch is high instead, the byte goes to the next lane of the address register. The first two address bytes of a sequence also reload the internal column counter.

A read-strobe fall presents the next output byte and advances the column counter. After the identification command, the output bytes come from a parameterised identification string, with the maker code first and the device code second. Outside identification mode the bus returns the erased value FFh, because the array itself lies outside this block. A confirm command that follows its matching setup command starts a programmable busy timer. While that timer runs, ready/busy is held low. Write-protect blocks the program and erase confirms but not the read confirm. With the chip deselected and the device ready, the block reports low-power standby. While busy, deselection is ignored.

Top module: `nand_cmd_front`

## Requirements
- R1: With `ce_n` low and `rb_n` high, a rising edge of `we_n` while `cle` is high loads `io_in` into `cmd_o` on that clock edge. `cmd_o` resets to FFh.
- R2: A rising edge of `we_n` with `ale` high and `cle` low stores `io_in` in byte lane k of `addr_o` (bits 8k+7..8k), where k counts the address bytes since the last command. Bytes beyond `ADDR_BYTES` are dropped.
- R3: Address byte 0 loads the column counter with `io_in`, upper bits cleared. Address byte 1 loads the column bits above bit 7 from the low bits of `io_in`.
- R4: While `cmd_o` is 90h, each accepted read-strobe fall puts identification byte number `column` on `io_out`. Byte 0 is 98h, byte 1 is DAh, and bytes 2 to 4 come from `ID_CODE`. From column `ID_LEN` upward the byte is 00h. In any other mode the byte is FFh.
- R5: Each accepted falling edge of `re_n` (`ce_n` low, ready) advances the column by one. `io_out` changes only on such an edge.
- R6: A confirm command drives `rb_n` low for exactly `BUSY_CYCLES` clock cycles, starting from the confirming edge. The confirm commands are 10h after 80h, D0h after 60h, and 30h after 00h, each as the previous command.
- R7: If `wp_n` is low when 10h or D0h is confirmed, busy does not start. The 30h read confirm starts busy whatever the state of `wp_n`.
- R8: While ready, `standby` follows `ce_n` one clock later: high when deselected, low when selected.
- R9: While `rb_n` is low, `standby` stays low whatever `ce_n` does. Write and read strobes leave `cmd_o`, `addr_o` and `io_out` unchanged.
- R10: `io_oe` rises only one clock after an accepted `re_n` fall with `ce_n` low. It falls one clock after `re_n` or `ce_n` goes high, and it is never high together with `standby`.
- R11: Strobes given while `ce_n` is high change neither `cmd_o` nor `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, acts on rising edge |
| re_n | input | 1 | Read strobe, acts on falling edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte from host |
| io_out | output | 8 | Bus byte to host |
| io_oe | output | 1 | Output enable for `io_out` |
| rb_n | output | 1 | Ready (1) / busy (0) |
| standby | output | 1 | Low-power standby indication |
| cmd_o | output | 8 | Last latched command |
| addr_o | output | ADDR_BYTES*8 | Latched address bytes, lane 0 lowest |

## Verification
The bench builds the block with `BUSY_CYCLES` set to 6, so several complete busy windows fit in a short run. Within those windows it toggles chip select and pulses strobes, and it can also observe the return to ready. `ADDR_BYTES` stays at 5, so a seven-byte address burst shows the dropping of excess bytes. `ID_LEN` stays at 5, so a read burst of seven bytes walks past the end of the identification string into the 00h region.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
    localparam logic [7:0] OP_ID       = 8'h90;
    localparam logic [7:0] OP_RD_SETUP = 8'h00;
    localparam logic [7:0] OP_RD_GO    = 8'h30;
    localparam logic [7:0] OP_PG_SETUP = 8'h80;
    localparam logic [7:0] OP_PG_GO    = 8'h10;
    localparam logic [7:0] OP_ER_SETUP = 8'h60;
    localparam logic [7:0] OP_ER_GO    = 8'hD0;
    localparam logic [7:0] BUS_IDLE    = 8'hFF;

    // A confirm is accepted only directly after its own setup command.
    function automatic logic starts_busy(input logic [7:0] prev,
                                         input logic [7:0] op,
                                         input logic       wp_n);
        return (prev == OP_RD_SETUP && op == OP_RD_GO) ||
               (prev == OP_PG_SETUP && op == OP_PG_GO && wp_n) ||
               (prev == OP_ER_SETUP && op == OP_ER_GO && wp_n);
    endfunction
endpackage

// File: rtl/nfe_strobe_edge.sv
module nfe_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] s_n,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_edge
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= s_n[i];
        end
        assign rise[i] = s_n[i] & ~prev_q;
        assign fall[i] = ~s_n[i] & prev_q;
    end
endmodule

// File: rtl/nfe_id_rom.sv
module nfe_id_rom #(
    parameter int               COL_W   = 12,
    parameter int               ID_LEN  = 5,
    parameter logic [ID_LEN*8-1:0] ID_CODE = 40'h76_15_90_DA_98
) (
    input  logic [COL_W-1:0] col,
    output logic [7:0]       id_byte
);
    always_comb begin
        id_byte = 8'h00;
        for (int i = 0; i < ID_LEN; i++) begin
            if (col == COL_W'(i)) id_byte = ID_CODE[i*8 +: 8];
        end
    end
endmodule

// File: rtl/nfe_busy_timer.sv
module nfe_busy_timer #(
    parameter int BUSY_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nfe_pkg::*;
#(
    parameter int                  ADDR_BYTES  = 5,
    parameter int                  COL_W       = 12,
    parameter int                  BUSY_CYCLES = 32,
    parameter int                  ID_LEN      = 5,
    parameter logic [ID_LEN*8-1:0] ID_CODE     = 40'h76_15_90_DA_98
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    cle,
    input  logic                    ale,
    input  logic                    we_n,
    input  logic                    re_n,
    input  logic                    wp_n,
    input  logic [7:0]              io_in,
    output logic [7:0]              io_out,
    output logic                    io_oe,
    output logic                    rb_n,
    output logic                    standby,
    output logic [7:0]              cmd_o,
    output logic [ADDR_BYTES*8-1:0] addr_o
);
    localparam int AIDX_W = $clog2(ADDR_BYTES + 1);
    localparam int HI_W   = COL_W - 8;

    typedef struct packed {
        logic [7:0]              cmd;
        logic [ADDR_BYTES*8-1:0] addr;
        logic [AIDX_W-1:0]       aidx;
        logic [COL_W-1:0]        col;
        logic [7:0]              dout;
        logic                    oe;
        logic                    stby;
    } fe_state_t;

    fe_state_t s_d, s_q;

    logic [1:0] st_rise, st_fall;
    logic       busy, start, ready, sel, we_up, re_dn;
    logic [7:0] id_byte;

    nfe_strobe_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .s_n  ({re_n, we_n}),
        .rise (st_rise),
        .fall (st_fall)
    );

    nfe_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .busy (busy)
    );

    nfe_id_rom #(.COL_W(COL_W), .ID_LEN(ID_LEN), .ID_CODE(ID_CODE)) u_id (
        .col    (s_q.col),
        .id_byte(id_byte)
    );

    assign ready = ~busy;
    assign sel   = ~ce_n & ready;
    assign we_up = sel & st_rise[0];
    assign re_dn = sel & st_fall[1];

    always_comb begin
        s_d   = s_q;
        start = 1'b0;
        if (we_up && cle) begin
            s_d.cmd  = io_in;
            s_d.aidx = '0;
            start    = starts_busy(s_q.cmd, io_in, wp_n);
        end else if (we_up && ale && s_q.aidx < AIDX_W'(ADDR_BYTES)) begin
            for (int i = 0; i < ADDR_BYTES; i++) begin
                if (s_q.aidx == AIDX_W'(i)) s_d.addr[i*8 +: 8] = io_in;
            end
            if (s_q.aidx == AIDX_W'(0)) s_d.col = COL_W'(io_in);
            if (s_q.aidx == AIDX_W'(1)) s_d.col[COL_W-1:8] = io_in[HI_W-1:0];
            s_d.aidx = s_q.aidx + 1'b1;
        end
        if (re_dn) begin
            s_d.dout = (s_q.cmd == OP_ID) ? id_byte : BUS_IDLE;
            s_d.col  = s_q.col + 1'b1;
        end
        s_d.oe   = ~ce_n & ~re_n & (s_q.oe | re_dn);
        s_d.stby = ce_n & ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cmd  <= BUS_IDLE;
            s_q.dout <= BUS_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign io_out  = s_q.dout;
    assign io_oe   = s_q.oe;
    assign rb_n    = ready;
    assign standby = s_q.stby;
    assign cmd_o   = s_q.cmd;
    assign addr_o  = s_q.addr;
endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk #(
    parameter int BUSY_CYCLES = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       cle,
    input logic       we_n,
    input logic       re_n,
    input logic [7:0] io_out,
    input logic       io_oe,
    input logic       rb_n,
    input logic       standby,
    input logic [7:0] cmd_o
);
    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     low_cnt <= 0;
        else if (!rb_n) low_cnt <= low_cnt + 1;
        else            low_cnt <= 0;
    end

    // R1
    cmd_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> $past(cle && !ce_n && we_n && rb_n));

    // R5
    dout_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(io_out) |-> $past(!re_n && !ce_n && rb_n));

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n) |-> $past(cle && !ce_n && we_n));

    // R6
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_n) |-> (low_cnt == BUSY_CYCLES));

    // R9
    busy_no_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_n |-> !standby);

    // R10
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_oe) |-> $past(!re_n && !ce_n));

    // R10
    oe_not_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> !standby);
endmodule

bind nand_cmd_front nand_cmd_front_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .cle    (cle),
    .we_n   (we_n),
    .re_n   (re_n),
    .io_out (io_out),
    .io_oe  (io_oe),
    .rb_n   (rb_n),
    .standby(standby),
    .cmd_o  (cmd_o)
);

// File: tb/nand_cmd_front_tb.sv
`timescale 1ns/1ps
module nand_cmd_front_tb;
    localparam int AB = 5;
    localparam int BC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out, cmd_o;
    logic io_oe, rb_n, standby;
    logic [AB*8-1:0] addr_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nand_cmd_front #(.ADDR_BYTES(AB), .COL_W(12), .BUSY_CYCLES(BC),
                     .ID_LEN(5), .ID_CODE(40'h76_15_90_DA_98)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n), .standby(standby),
        .cmd_o(cmd_o), .addr_o(addr_o)
    );

    // ---------------- behavioural reference ----------------
    int m_cmd, m_aidx, m_col, m_dout, m_busy;
    bit m_oe, m_stby, p_we, p_re;
    int m_addr[AB];

    function automatic int id_of(input int c);
        case (c)
            0: return 'h98;
            1: return 'hDA;
            2: return 'h90;
            3: return 'h15;
            4: return 'h76;
            default: return 0;
        endcase
    endfunction

    task automatic m_reset();
        m_cmd = 'hFF; m_aidx = 0; m_col = 0; m_dout = 'hFF; m_busy = 0;
        m_oe = 0; m_stby = 0; p_we = 1; p_re = 1;
        foreach (m_addr[i]) m_addr[i] = 0;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (rst_n) begin
            bit rdy, ok_sel, wr, rdf;
            int nb;
            rdy    = (m_busy == 0);
            ok_sel = !ce_n && rdy;
            wr     = ok_sel && we_n && !p_we;
            rdf    = ok_sel && !re_n && p_re;
            nb     = (m_busy > 0) ? m_busy - 1 : 0;
            if (wr && cle) begin
                if ((m_cmd == 'h00 && io_in == 8'h30) ||
                    (m_cmd == 'h80 && io_in == 8'h10 && wp_n) ||
                    (m_cmd == 'h60 && io_in == 8'hD0 && wp_n)) nb = BC;
                m_cmd = io_in; m_aidx = 0;
            end else if (wr && ale && m_aidx < AB) begin
                m_addr[m_aidx] = io_in;
                if (m_aidx == 0) m_col = io_in;
                if (m_aidx == 1) m_col = (m_col & 'hFF) | ((io_in & 'hF) << 8);
                m_aidx++;
            end
            m_oe = !ce_n && !re_n && (m_oe || rdf);
            if (rdf) begin
                m_dout = (m_cmd == 'h90) ? id_of(m_col) : 'hFF;
                m_col  = (m_col + 1) % 4096;
            end
            m_stby = ce_n && rdy;
            m_busy = nb;
            p_we = we_n; p_re = re_n;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // compare on every clock, half a period after the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [AB*8-1:0] ea;
            for (int i = 0; i < AB; i++) ea[i*8 +: 8] = m_addr[i][7:0];
            check("R1 cmd_o", cmd_o, m_cmd);
            check("R2 addr_o", (addr_o == ea) ? 1 : 0, 1);
            check("R4 io_out", io_out, m_dout);
            check("R6 rb_n", rb_n, (m_busy == 0) ? 1 : 0);
            check("R8 standby", standby, m_stby);
            check("R10 io_oe", io_oe, m_oe);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic wr(input bit c, input bit a, input logic [7:0] d);
        step(1); cle = c; ale = a; io_in = d; we_n = 1'b0;
        step(1); we_n = 1'b1;
        step(1); cle = 1'b0; ale = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        step(1); re_n = 1'b0;
        step(1); v = io_out; check("R10 oe during read", io_oe, 1);
        re_n = 1'b1;
        step(1);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] ids[7];
        ids = '{8'h98, 8'hDA, 8'h90, 8'h15, 8'h76, 8'h00, 8'h00};
        step(3); rst_n = 1'b1; step(1);
        check("R1 reset cmd_o", cmd_o, 'hFF);
        check("R6 reset rb_n", rb_n, 1);
        check("R8 reset standby", standby, 0);

        // R4 R5: ID read past the end of the string
        wr(1, 0, 8'h90); wr(0, 1, 8'h00);
        for (int i = 0; i < 7; i++) begin
            rd(v); check("R4 id byte", v, ids[i]);
        end
        // R3: new address sequence reloads the column
        wr(1, 0, 8'h90); wr(0, 1, 8'h02);
        rd(v); check("R3 column reload", v, 'h90);
        rd(v); check("R5 column step", v, 'h15);

        // R6 R9: erase with busy window, deselect and strobes ignored
        wr(1, 0, 8'h60); wr(0, 1, 8'h11); wr(0, 1, 8'h22); wr(0, 1, 8'h03);
        wr(1, 0, 8'hD0);
        check("R6 busy after erase confirm", rb_n, 0);
        ce_n = 1'b1; step(1);
        check("R9 no standby while busy", standby, 0);
        ce_n = 1'b0;
        cle = 1'b1; io_in = 8'h90; we_n = 1'b0; step(1); we_n = 1'b1; step(1); cle = 1'b0;
        check("R9 cmd held while busy", cmd_o, 'hD0);
        step(BC);
        check("R6 ready after window", rb_n, 1);

        // R7: write-protected program blocked, read confirm not blocked
        wp_n = 1'b0;
        wr(1, 0, 8'h80); for (int i = 0; i < 5; i++) wr(0, 1, 8'(8'h40 + i));
        wr(1, 0, 8'h10);
        check("R7 program blocked", rb_n, 1);
        wr(1, 0, 8'h60); wr(0, 1, 8'h01); wr(1, 0, 8'hD0);
        check("R7 erase blocked", rb_n, 1);
        wr(1, 0, 8'h00); wr(0, 1, 8'h05); wr(1, 0, 8'h30);
        check("R7 read confirm busy", rb_n, 0);
        wp_n = 1'b1; step(BC + 1);

        // R2: seven address bytes, last two dropped
        wr(1, 0, 8'h80);
        for (int i = 0; i < 7; i++) wr(0, 1, 8'(8'hA0 + i));
        check("R2 lane 4", addr_o[39:32], 'hA4);
        check("R2 lane 0", addr_o[7:0], 'hA0);
        // R6: confirm after 80h with wp high starts busy
        wr(1, 0, 8'h10);
        check("R6 program busy", rb_n, 0);
        step(BC + 1);

        // R4: data read mode returns FFh
        wr(1, 0, 8'h00); wr(0, 1, 8'h00); 
        rd(v); check("R4 non-id byte", v, 'hFF);

        // R8 R11: deselect while ready, strobes ignored
        ce_n = 1'b1; step(2);
        check("R8 standby when deselected", standby, 1);
        wr(1, 0, 8'h90); wr(0, 1, 8'h77);
        check("R11 cmd unchanged", cmd_o, 'h00);
        check("R11 addr unchanged", addr_o[7:0], 'h00);
        step(1); re_n = 1'b0; step(1);
        check("R10 no oe when deselected", io_oe, 0);
        re_n = 1'b1;
        ce_n = 1'b0; step(2);
        check("R8 standby cleared", standby, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule